// File: doc/BRIEF.md
# Flow-through late-write SRAM core

This block is a synchronous single-port memory built from a small register array, 64 words of 18 bits by default, split into two 9-bit byte lanes. A read returns data combinationally from the address registered at the previous rising edge, so the word is ready within the cycle that follows its command. A write registers its address and command at one rising edge and takes its data at the next enabled edge. Because of this one-cycle data lag on writes, read and write commands can alternate on every cycle with no idle slot on the shared data bus.

Each operation starts with a load command. A load uses the external address and the current chip-select state to begin a read, a write or a deselect. An advance command keeps the current operation type and steps a 2-bit burst counter. The counter runs either in wrapping linear order or in XOR (interleaved) order. A clock-enable input freezes the whole block. An asynchronous output enable gates the output-drive signal. The data bus is split into `din`, `dout` and `dout_en`, and the pad tristate sits outside the block.

Top module: `ftsram_core`

## Requirements
- R1: While `rst_n` is low, and after its release until the first read command, `dout_en` is 0 and `dout` is all zeros.
- R2: A load (`cke_n`=0, `ld_n`=0) with all selects active (`cs1_n`=0, `cs2`=1, `cs3_n`=0) and `we_n`=1 starts a read. In the following cycle, with `oe_n`=0, `dout_en` is 1 and `dout` holds the word at the latched address.
- R3: A load with all selects active and `we_n`=0 starts a write. The word on `din` at the next enabled edge is stored at the address latched by the load.
- R4: `bw_n` is active low and is sampled at the command edge. `bw_n[0]` guards data bits 8:0 and `bw_n[1]` guards bits 17:9. A lane whose bit is high keeps its old contents, and `bw_n`=2'b11 makes the write a no-op.
- R5: A read loaded at the edge that captures a write's data, to the same address, returns the newly written word. Reads and writes may alternate on every cycle.
- R6: While `cke_n`=1, all synchronous inputs are ignored, and the current operation, the address and any pending write hold. The pending write takes its data at the next edge where `cke_n`=0.
- R7: An advance (`ld_n`=1) during an active operation keeps the read or write type and the upper address bits. With `seq_linear`=1 the low two address bits go start+k mod 4; with `seq_linear`=0 they go start XOR k, for beat k=0..3.
- R8: A load with any select inactive deselects the block. An advance while deselected stays deselected, and only a new load starts an operation.
- R9: `oe_n`=1 drops `dout_en` to 0 and `dout` to zero at once, with no clock edge needed.
- R10: During write cycles and deselected cycles `dout_en` is 0, whatever the value of `oe_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| cke_n | input | 1 | Active-low clock enable; high freezes the block |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| ld_n | input | 1 | Low: load a new command; high: advance the burst |
| we_n | input | 1 | Low: write, high: read (sampled on load) |
| bw_n | input | LANES | Active-low byte-lane write enables |
| addr | input | ADDR_W | External word address |
| seq_linear | input | 1 | Burst order: 1 linear, 0 interleaved (static) |
| oe_n | input | 1 | Asynchronous active-low output enable |
| din | input | LANES*LANE_W | Write data, one cycle after its command |
| dout | output | LANES*LANE_W | Read data, zero when not driving |
| dout_en | output | 1 | Drive enable for the external data pads |

## Verification
On every cycle, the checker confirms that a load latches the address, that deselects persist through advances, and that advances keep the operation type and upper address bits. It also confirms that a frozen clock enable holds all state and that `dout_en` stays low during writes, deselects and while `oe_n` is high. The stored contents cannot be checked per cycle: the burst address orders, the byte-lane merging, the write-to-read forwarding and the delayed data capture across a stall are shown only by the bench. The bench fills the whole array and reads it back, and sweeps every burst start in both orders.

// File: rtl/ftsram_pkg.sv
package ftsram_pkg;
   typedef enum logic {
      OP_RD = 1'b0,
      OP_WR = 1'b1
   } op_e;
endpackage

// File: rtl/ftsram_burst.sv
// Burst beat counter and low-address mapping.
module ftsram_burst #(
   parameter int BURST_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               step,
   input  logic               seq_linear,
   input  logic [BURST_W-1:0] start,
   output logic [BURST_W-1:0] lo
);
   logic [BURST_W-1:0] beat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    beat_q <= '0;
      else if (load) beat_q <= '0;
      else if (step) beat_q <= beat_q + 1'b1;
   end

   // the sum wraps inside BURST_W bits, matching the counter wrap
   assign lo = seq_linear ? (start + beat_q) : (start ^ beat_q);
endmodule

// File: rtl/ftsram_ctrl.sv
// Command decode: operation type, latched address, lane mask.
module ftsram_ctrl
   import ftsram_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cke_n,
   input  logic              sel,
   input  logic              ld_n,
   input  logic              we_n,
   input  logic [LANES-1:0]  bw_n,
   input  logic [ADDR_W-1:0] addr,
   output logic              act_q,
   output op_e               op_q,
   output logic [ADDR_W-1:0] base_q,
   output logic [LANES-1:0]  lane_n_q,
   output logic              load,
   output logic              step,
   output logic              commit
);
   logic en;

   assign en     = !cke_n;
   assign load   = en && !ld_n && sel;
   assign step   = en && ld_n && act_q;
   // the cycle that just ended was a write beat: its data is on din now
   assign commit = en && act_q && (op_q == OP_WR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q    <= 1'b0;
         op_q     <= OP_RD;
         base_q   <= '0;
         lane_n_q <= '1;
      end else if (en) begin
         lane_n_q <= bw_n;
         if (!ld_n) begin
            act_q <= sel;
            if (sel) begin
               op_q   <= we_n ? OP_RD : OP_WR;
               base_q <= addr;
            end
         end
      end
   end
endmodule

// File: rtl/ftsram_array.sv
// Register array, one bank per byte lane, asynchronous read.
module ftsram_array #(
   parameter int ADDR_W = 6,
   parameter int LANE_W = 9,
   parameter int LANES  = 2
) (
   input  logic                    clk,
   input  logic                    we,
   input  logic [LANES-1:0]        lane_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] bank [DEPTH];

      always_ff @(posedge clk) begin
         if (we && !lane_n[g]) bank[addr] <= wdata[g*LANE_W +: LANE_W];
      end

      assign rdata[g*LANE_W +: LANE_W] = bank[addr];
   end
endmodule

// File: rtl/ftsram_core.sv
module ftsram_core
   import ftsram_pkg::*;
#(
   parameter int ADDR_W  = 6,
   parameter int LANE_W  = 9,
   parameter int LANES   = 2,
   parameter int BURST_W = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cke_n,
   input  logic                    cs1_n,
   input  logic                    cs2,
   input  logic                    cs3_n,
   input  logic                    ld_n,
   input  logic                    we_n,
   input  logic [LANES-1:0]        bw_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    seq_linear,
   input  logic                    oe_n,
   input  logic [LANES*LANE_W-1:0] din,
   output logic [LANES*LANE_W-1:0] dout,
   output logic                    dout_en
);
   localparam int DATA_W = LANES * LANE_W;

   if (BURST_W < 1 || BURST_W >= ADDR_W) begin : g_bad_burst
      $error("ftsram_core: BURST_W must lie in 1..ADDR_W-1");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("ftsram_core: LANES and LANE_W must be positive");
   end

   logic               sel;
   logic               act_q;
   op_e                op_q;
   logic               is_wr;
   logic [ADDR_W-1:0]  base_q;
   logic [LANES-1:0]   lane_n_q;
   logic               load, step, commit;
   logic [BURST_W-1:0] lo;
   logic [ADDR_W-1:0]  cur_addr;
   logic [DATA_W-1:0]  rdata;

   assign sel   = !cs1_n && cs2 && !cs3_n;
   assign is_wr = (op_q == OP_WR);

   ftsram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .sel(sel), .ld_n(ld_n),
      .we_n(we_n), .bw_n(bw_n), .addr(addr), .act_q(act_q), .op_q(op_q),
      .base_q(base_q), .lane_n_q(lane_n_q), .load(load), .step(step),
      .commit(commit)
   );

   ftsram_burst #(.BURST_W(BURST_W)) u_burst (
      .clk(clk), .rst_n(rst_n), .load(load), .step(step),
      .seq_linear(seq_linear), .start(base_q[BURST_W-1:0]), .lo(lo)
   );

   assign cur_addr = {base_q[ADDR_W-1:BURST_W], lo};

   ftsram_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
      .clk(clk), .we(commit), .lane_n(lane_n_q), .addr(cur_addr),
      .wdata(din), .rdata(rdata)
   );

   assign dout_en = act_q && !is_wr && !oe_n;
   assign dout    = dout_en ? rdata : '0;
endmodule

// File: rtl/ftsram_chk.sv
module ftsram_chk #(
   parameter int ADDR_W  = 6,
   parameter int BURST_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cke_n,
   input logic              ld_n,
   input logic              we_n,
   input logic              sel,
   input logic              oe_n,
   input logic [ADDR_W-1:0] addr,
   input logic              dout_en,
   input logic              act_q,
   input logic              is_wr,
   input logic [ADDR_W-1:0] cur_addr
);
   p_load_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_n && !ld_n && sel) |=> (act_q && cur_addr == $past(addr)));

   p_write_type_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_n && !ld_n && sel && !we_n) |=> is_wr);

   p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cke_n |=> ($stable(cur_addr) && $stable(act_q) && $stable(is_wr)));

   p_adv_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_n && ld_n && act_q) |=> (act_q && is_wr == $past(is_wr) &&
         cur_addr[ADDR_W-1:BURST_W] == $past(cur_addr[ADDR_W-1:BURST_W])));

   p_desel_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_n && !ld_n && !sel) |=> (!act_q && !dout_en));

   p_desel_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_n && ld_n && !act_q) |=> !act_q);

   p_oe_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !dout_en);

   p_wr_nodrive_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_n && !ld_n && sel && !we_n) |=> !dout_en);
endmodule

bind ftsram_core ftsram_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .ld_n(ld_n), .we_n(we_n),
   .sel(sel), .oe_n(oe_n), .addr(addr), .dout_en(dout_en), .act_q(act_q),
   .is_wr(is_wr), .cur_addr(cur_addr)
);

// File: tb/sim_ftsram_core.sv
`timescale 1ns/1ps
module sim_ftsram_core;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n, cke_n, cs1_n, cs2, cs3_n, ld_n, we_n, seq_linear, oe_n;
   logic [1:0]  bw_n;
   logic [5:0]  addr;
   logic [17:0] din;
   logic [17:0] dout;
   logic        dout_en;
   logic [17:0] mem_m [64];
   int          checks = 0;
   int          failures = 0;

   always #(CLK_P/2) clk = ~clk;

   ftsram_core u0 (
      .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .cs1_n(cs1_n), .cs2(cs2),
      .cs3_n(cs3_n), .ld_n(ld_n), .we_n(we_n), .bw_n(bw_n), .addr(addr),
      .seq_linear(seq_linear), .oe_n(oe_n), .din(din), .dout(dout),
      .dout_en(dout_en)
   );

   function automatic logic [17:0] pat(input int a);
      return 18'((a * 4099 + 341) & 18'h3FFFF);
   endfunction

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic ld(input logic wr, input logic [5:0] a, input logic [1:0] bw,
                     input logic [17:0] d);
      cke_n = 0; ld_n = 0; cs1_n = 0; cs2 = 1; cs3_n = 0;
      we_n = !wr; addr = a; bw_n = bw; din = d;
      tick();
   endtask

   task automatic adv(input logic [1:0] bw, input logic [17:0] d);
      cke_n = 0; ld_n = 1; bw_n = bw; din = d; addr = 6'h3F;
      tick();
   endtask

   task automatic desel(input int which, input logic [17:0] d);
      cke_n = 0; ld_n = 0; cs1_n = 0; cs2 = 1; cs3_n = 0; din = d;
      if (which == 0) cs1_n = 1;
      else if (which == 1) cs2 = 0;
      else cs3_n = 1;
      tick();
      cs1_n = 0; cs2 = 1; cs3_n = 0;
   endtask

   initial begin
      #(CLK_P * 100000);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      rst_n = 0; cke_n = 0; cs1_n = 0; cs2 = 1; cs3_n = 0; ld_n = 0; we_n = 1;
      seq_linear = 1; oe_n = 0; bw_n = 2'b11; addr = 0; din = 0;
      repeat (3) tick();
      chk("R1 reset dout_en", 32'(dout_en), 0);
      chk("R1 reset dout", 32'(dout), 0);
      rst_n = 1;
      ld_n = 1; tick();
      chk("R1 idle after reset", 32'(dout_en), 0);

      // R3 / R7: fill the array with linear write bursts
      for (int b = 0; b < 16; b++) begin
         ld(1, 6'(b * 4), 2'b00, (b == 0) ? 18'h0 : pat(b * 4 - 1));
         chk("R10 write no drive", 32'(dout_en), 0);
         for (int k = 0; k < 3; k++) adv(2'b00, pat(b * 4 + k));
      end
      desel(1, pat(63));
      for (int a = 0; a < 64; a++) mem_m[a] = pat(a);

      // R2: read back every word
      for (int a = 0; a < 64; a++) begin
         ld(0, 6'(a), 2'b11, 18'h0);
         chk("R2 read drive", 32'(dout_en), 1);
         chk("R3 read data", 32'(dout), 32'(mem_m[a]));
      end

      // R7: bursts from every start in both orders
      for (int lin = 0; lin < 2; lin++) begin
         for (int s = 0; s < 4; s++) begin
            seq_linear = lin[0];
            ld(0, 6'(28 + s), 2'b11, 18'h0);
            chk("R7 burst beat0", 32'(dout), 32'(mem_m[28 + s]));
            for (int k = 1; k < 4; k++) begin
               int lo;
               adv(2'b11, 18'h0);
               lo = lin ? ((s + k) & 3) : (s ^ k);
               chk("R7 burst beat", 32'(dout), 32'(mem_m[28 + lo]));
            end
         end
      end

      // R7: interleaved write burst starting at low bits 3
      seq_linear = 0;
      ld(1, 6'd43, 2'b00, 18'h0);
      adv(2'b00, 18'h1A001);
      chk("R7 write burst type kept", 32'(dout_en), 0);
      adv(2'b00, 18'h1A002);
      adv(2'b00, 18'h1A003);
      desel(0, 18'h1A004);
      mem_m[43] = 18'h1A001; mem_m[42] = 18'h1A002;
      mem_m[41] = 18'h1A003; mem_m[40] = 18'h1A004;
      seq_linear = 1;
      for (int a = 40; a < 44; a++) begin
         ld(0, 6'(a), 2'b11, 18'h0);
         chk("R7 interleaved write", 32'(dout), 32'(mem_m[a]));
      end

      // R4 / R5: byte lanes, read loaded on the capture edge
      ld(1, 6'd10, 2'b10, 18'h0);
      ld(0, 6'd10, 2'b11, 18'h2AAAA);
      mem_m[10] = {mem_m[10][17:9], 9'h0AA};
      chk("R4 lane0 only", 32'(dout), 32'(mem_m[10]));
      ld(1, 6'd10, 2'b01, 18'h0);
      ld(0, 6'd10, 2'b11, 18'h15555);
      mem_m[10] = {9'h0AA, mem_m[10][8:0]};
      chk("R4 lane1 only", 32'(dout), 32'(mem_m[10]));
      ld(1, 6'd10, 2'b11, 18'h0);
      ld(0, 6'd10, 2'b11, 18'h3FFFF);
      chk("R4 abort unchanged", 32'(dout), 32'(mem_m[10]));
      ld(1, 6'd10, 2'b00, 18'h0);
      ld(0, 6'd10, 2'b11, 18'h0F0F0);
      mem_m[10] = 18'h0F0F0;
      chk("R5 bypass full word", 32'(dout), 32'(mem_m[10]));

      // R5 / R10: write and read alternate every cycle
      for (int i = 0; i < 8; i++) begin
         ld(1, 6'(32 + i), 2'b00, 18'h0);
         chk("R10 write cycle oe low", 32'(dout_en), 0);
         ld(0, 6'(32 + i), 2'b11, 18'(18'h30000 + i * 7));
         mem_m[32 + i] = 18'(18'h30000 + i * 7);
         chk("R5 alternate read", 32'(dout), 32'(mem_m[32 + i]));
      end

      // R6: pending write held across a stall
      ld(1, 6'd20, 2'b00, 18'h0);
      cke_n = 1; ld_n = 0; we_n = 1; addr = 6'd21; din = 18'h11111; bw_n = 2'b11;
      repeat (3) tick();
      chk("R6 stall keeps write", 32'(dout_en), 0);
      ld(0, 6'd20, 2'b11, 18'h2BCDE);
      mem_m[20] = 18'h2BCDE;
      chk("R6 data at enabled edge", 32'(dout), 32'(mem_m[20]));
      ld(0, 6'd21, 2'b11, 18'h0);
      chk("R6 stall data not written", 32'(dout), 32'(mem_m[21]));
      ld(0, 6'd5, 2'b11, 18'h0);
      cke_n = 1; addr = 6'd9; we_n = 0; ld_n = 0; cs2 = 0;
      tick(); tick();
      chk("R6 read held", 32'(dout), 32'(mem_m[5]));
      chk("R6 drive held", 32'(dout_en), 1);
      cs2 = 1;

      // R8: each select deselects; advance stays deselected
      for (int w = 0; w < 3; w++) begin
         ld(0, 6'd3, 2'b11, 18'h0);
         chk("R8 read before desel", 32'(dout_en), 1);
         desel(w, 18'h0);
         chk("R8 deselected", 32'(dout_en), 0);
         adv(2'b11, 18'h0);
         chk("R8 advance stays deselected", 32'(dout_en), 0);
      end
      ld(0, 6'd3, 2'b11, 18'h0);
      chk("R8 load restarts", 32'(dout), 32'(mem_m[3]));

      // R9: asynchronous output enable
      ld(0, 6'd4, 2'b11, 18'h0);
      oe_n = 1; #1;
      chk("R9 oe off drive", 32'(dout_en), 0);
      chk("R9 oe off data", 32'(dout), 0);
      oe_n = 0; #1;
      chk("R9 oe on data", 32'(dout), 32'(mem_m[4]));

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule